// File: doc/BRIEF.md
# ADC Threshold Alert Comparator

This block sits beside an ADC's conversion path. It watches each signed conversion result as it arrives and drives an alert pin when results leave a programmed band. Results and thresholds are left-justified in a 16-bit word. Only the upper `RES_BITS` bits carry the value, and the lower pad bits are ignored. Two 16-bit threshold registers and a five-bit comparator setting are loaded through a simple write port, addressed by register index.

The comparator has two modes. In traditional mode it raises the alert when a result goes above the high threshold, and releases it only when a result goes below the low threshold, which gives hysteresis. In window mode it flags any result outside the band and releases on the first result inside it. A fault queue asks for 1, 2 or 4 out-of-range results in a row before the alert fires, and one queue code turns the comparator off. In latching mode the alert holds until the conversion register is read, which is marked by a read strobe. The pin polarity can be set to active-low or active-high.

Top module: `thresh_alert_top`

## Requirements
- R1: After reset the comparator is off (queue code 3), polarity is active-low so `alertPin` is 1, the low threshold is 0x8000 and the high threshold is 0x7FFF. With those thresholds no result triggers the alert in either mode.
- R2: While the queue field (setting bits [1:0], written at index 1) is 3, the alert is inactive whatever results arrive. Writing code 3 clears an active alert at once.
- R3: In traditional mode (setting bit 4 = 0), a result strictly greater than the high threshold (index 3) counts as out of range. A result equal to the high threshold does not.
- R4: In traditional mode without latching, an active alert stays up for results between the thresholds. It drops only on a result strictly below the low threshold (index 2).
- R5: In window mode (bit 4 = 1), a result above the high threshold or below the low threshold raises the alert. Without latching, the first result inside the band drops it.
- R6: Queue code 0 fires on 1 out-of-range result, code 1 on 2 consecutive results, and code 2 on 4 consecutive results. Any in-range result resets the run count to zero.
- R7: With latching (bit 2 = 1), the alert holds through any results until `convRead` pulses, and that pulse clears it.
- R8: Without latching, `convRead` has no effect on the alert.
- R9: Polarity bit 3 = 1 makes `alertPin` active-high. Bit 3 = 0 makes it active-low.
- R10: Comparisons are signed two's complement on bits [15:4] only. Bits [3:0] of results and thresholds have no effect.
- R11: A setting write that changes the queue code resets the run count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register index: 1 setting, 2 low threshold, 3 high threshold; index 0 is read-only |
| wrData | input | 16 | Write data |
| sampleValid | input | 1 | A new conversion result is present this cycle |
| sampleData | input | 16 | Left-justified signed conversion result |
| convRead | input | 1 | Conversion register read strobe |
| alertPin | output | 1 | Alert output with programmable polarity |

## Verification
Traditional mode is driven with a climb past the high threshold, a return between the thresholds and a drop below the low one. This separates hysteresis from a plain band check. The same shape is then run in window mode, where the in-band return must release the alert. Runs of 2, 3 and 4 out-of-range results, some broken by an in-range result and one interrupted by a queue-code change, show whether the run counter counts, saturates and resets as required. Results that differ from a threshold only in the pad bits, and negative results that would look large if compared unsigned, expose a comparison that uses the wrong width or the wrong signedness.

// File: rtl/tac_pkg.sv
package tac_pkg;

  typedef enum logic [1:0] {
    QUE_ONE  = 2'd0,
    QUE_TWO  = 2'd1,
    QUE_FOUR = 2'd2,
    QUE_OFF  = 2'd3
  } queCode_t;

  typedef struct packed {
    logic     windowMode;
    logic     activeHigh;
    logic     latchOn;
    queCode_t queue;
  } cmpCfg_t;

  localparam int CFG_BITS = $bits(cmpCfg_t);

  typedef struct packed {
    logic sampleStb;
    logic aboveHigh;
    logic belowLow;
    logic queueChanged;
    logic disableNow;
  } cmpStrobes_t;

  localparam logic [1:0] IDX_CONV = 2'd0;
  localparam logic [1:0] IDX_CFG  = 2'd1;
  localparam logic [1:0] IDX_LOW  = 2'd2;
  localparam logic [1:0] IDX_HIGH = 2'd3;

endpackage

// File: rtl/tac_regs.sv
module tac_regs
  import tac_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output cmpCfg_t           cfg,
  output logic [DATA_W-1:0] lowThr,
  output logic [DATA_W-1:0] highThr,
  output logic              queueChanged,
  output logic              disableNow
);

  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam cmpCfg_t CFG_RESET = '{windowMode: 1'b0, activeHigh: 1'b0,
                                    latchOn: 1'b0, queue: QUE_OFF};

  logic    hitCfg;
  logic    hitLow;
  logic    hitHigh;
  cmpCfg_t newCfg;
  logic    unusedCfgBits;

  assign hitCfg  = wrEn && (wrAddr == ADDR_W'(IDX_CFG));
  assign hitLow  = wrEn && (wrAddr == ADDR_W'(IDX_LOW));
  assign hitHigh = wrEn && (wrAddr == ADDR_W'(IDX_HIGH));
  assign newCfg  = cmpCfg_t'(wrData[CFG_BITS-1:0]);
  assign unusedCfgBits = ^wrData[DATA_W-1:CFG_BITS];

  assign disableNow   = hitCfg && (newCfg.queue == QUE_OFF);
  assign queueChanged = hitCfg && (newCfg.queue != QUE_OFF) &&
                        (newCfg.queue != cfg.queue);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg     <= CFG_RESET;
      lowThr  <= MOST_NEG;
      highThr <= MOST_POS;
    end else begin
      if (hitCfg)  cfg     <= newCfg;
      if (hitLow)  lowThr  <= wrData;
      if (hitHigh) highThr <= wrData;
    end
  end

endmodule

// File: rtl/tac_datapath.sv
module tac_datapath
  import tac_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int RES_BITS = 12
) (
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  input  logic [DATA_W-1:0] lowThr,
  input  logic [DATA_W-1:0] highThr,
  input  logic              queueChanged,
  input  logic              disableNow,
  input  logic              activeHigh,
  input  logic              alertOn,
  output cmpStrobes_t       stb,
  output logic              alertPin
);

  localparam int PAD_BITS = DATA_W - RES_BITS;

  logic signed [RES_BITS-1:0] resVal;
  logic signed [RES_BITS-1:0] lowVal;
  logic signed [RES_BITS-1:0] highVal;

  assign resVal  = sampleData[DATA_W-1 -: RES_BITS];
  assign lowVal  = lowThr[DATA_W-1 -: RES_BITS];
  assign highVal = highThr[DATA_W-1 -: RES_BITS];

  generate
    if (PAD_BITS > 0) begin : g_pad
      logic unusedPadBits;
      assign unusedPadBits = ^{sampleData[PAD_BITS-1:0], lowThr[PAD_BITS-1:0],
                               highThr[PAD_BITS-1:0]};
    end
  endgenerate

  always_comb begin
    stb.sampleStb    = sampleValid;
    stb.aboveHigh    = resVal > highVal;
    stb.belowLow     = resVal < lowVal;
    stb.queueChanged = queueChanged;
    stb.disableNow   = disableNow;
  end

  assign alertPin = activeHigh ? alertOn : ~alertOn;

endmodule

// File: rtl/tac_ctrl.sv
module tac_ctrl
  import tac_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  cmpStrobes_t      stb,
  input  logic             windowMode,
  input  logic             latchOn,
  input  queCode_t         queue,
  input  logic             convRead,
  output logic             alertOn,
  output logic [CNT_W-1:0] hitCount
);

  localparam logic [CNT_W-1:0] NEED_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] NEED_TWO  = CNT_W'(2);
  localparam logic [CNT_W-1:0] NEED_FOUR = CNT_W'(4);
  localparam logic [CNT_W-1:0] CNT_MAX   = NEED_FOUR;

  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] cntInc;
  logic [CNT_W-1:0] cntNext;
  logic             outOfRange;
  logic             releaseHit;
  logic             trigger;
  logic             alertNext;

  always_comb begin
    case (queue)
      QUE_ONE: need = NEED_ONE;
      QUE_TWO: need = NEED_TWO;
      default: need = NEED_FOUR;
    endcase
    outOfRange = stb.aboveHigh | (windowMode & stb.belowLow);
    releaseHit = windowMode ? !outOfRange : stb.belowLow;
    cntInc     = (hitCount >= CNT_MAX) ? CNT_MAX : hitCount + CNT_W'(1);
    trigger    = stb.sampleStb && outOfRange && (cntInc >= need);

    cntNext   = hitCount;
    alertNext = alertOn;
    if (stb.disableNow || queue == QUE_OFF) begin
      cntNext   = '0;
      alertNext = 1'b0;
    end else begin
      if (stb.queueChanged)   cntNext = '0;
      else if (stb.sampleStb) cntNext = outOfRange ? cntInc : '0;

      if (trigger)                             alertNext = 1'b1;
      else if (latchOn)                        alertNext = convRead ? 1'b0 : alertOn;
      else if (stb.sampleStb && releaseHit)    alertNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitCount <= '0;
      alertOn  <= 1'b0;
    end else begin
      hitCount <= cntNext;
      alertOn  <= alertNext;
    end
  end

endmodule

// File: rtl/thresh_alert_top.sv
module thresh_alert_top
  import tac_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 2,
  parameter int RES_BITS = 12,
  parameter int CNT_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              convRead,
  output logic              alertPin
);

  cmpCfg_t          cfg;
  cmpStrobes_t      stb;
  logic [DATA_W-1:0] lowThr;
  logic [DATA_W-1:0] highThr;
  logic             queueChanged;
  logic             disableNow;
  logic             alertOn;
  logic [CNT_W-1:0] hitCount;

  tac_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cfg(cfg), .lowThr(lowThr), .highThr(highThr),
    .queueChanged(queueChanged), .disableNow(disableNow)
  );

  tac_datapath #(.DATA_W(DATA_W), .RES_BITS(RES_BITS)) u_dp (
    .sampleValid(sampleValid), .sampleData(sampleData),
    .lowThr(lowThr), .highThr(highThr),
    .queueChanged(queueChanged), .disableNow(disableNow),
    .activeHigh(cfg.activeHigh), .alertOn(alertOn),
    .stb(stb), .alertPin(alertPin)
  );

  tac_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .stb(stb),
    .windowMode(cfg.windowMode), .latchOn(cfg.latchOn), .queue(cfg.queue),
    .convRead(convRead), .alertOn(alertOn), .hitCount(hitCount)
  );

endmodule

// File: rtl/tac_checker.sv
module tac_checker #(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              sampleValid,
  input logic              convRead,
  input logic [1:0]        queueCode,
  input logic              latchOn,
  input logic              alertOn,
  input logic              alertPin,
  input logic [CNT_W-1:0]  hitCount
);

  logic cfgWr;
  assign cfgWr = wrEn && (wrAddr == ADDR_W'(1));

  // R1: leaving reset gives an idle active-low pin
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> alertPin);

  // R2: comparator off means no alert
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (queueCode == 2'd3) |-> !alertOn);

  // R3: an alert only rises after a conversion arrived
  p_rise_after_sample_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alertOn) |-> $past(sampleValid));

  // R6: run count never passes the longest queue
  p_count_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    hitCount <= CNT_W'(4));

  // R7: latched alert holds until a read
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (latchOn && alertOn && !convRead && !cfgWr) |=> alertOn);

  // R7: a read with no new result clears a latched alert
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (latchOn && convRead && !sampleValid && !cfgWr) |=> !alertOn);

endmodule

bind thresh_alert_top tac_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
  .sampleValid(sampleValid), .convRead(convRead),
  .queueCode(cfg.queue), .latchOn(cfg.latchOn),
  .alertOn(alertOn), .alertPin(alertPin), .hitCount(hitCount)
);

// File: tb/tb_thresh_alert_top.sv
module tb_thresh_alert_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [1:0]  wrAddr;
  logic [15:0] wrData;
  logic        sampleValid;
  logic [15:0] sampleData;
  logic        convRead;
  logic        alertPin;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  thresh_alert_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sampleValid(sampleValid), .sampleData(sampleData),
    .convRead(convRead), .alertPin(alertPin)
  );

  function automatic logic [15:0] cfgWord(input logic win, input logic hiPol,
                                          input logic lat, input logic [1:0] que);
    return {11'd0, win, hiPol, lat, que};
  endfunction

  task automatic expectPin(input logic exp, input string tag);
    total++;
    if (alertPin !== exp) begin
      bad++;
      $display("FAIL %s: alertPin=%0b expected=%0b", tag, alertPin, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic sample(input logic [15:0] v);
    sampleValid = 1'b1; sampleData = v;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic readConv();
    convRead = 1'b1;
    @(negedge clk);
    convRead = 1'b0;
  endtask

  task automatic setup(input logic [15:0] lo, input logic [15:0] hi, input logic [15:0] c);
    writeReg(2'd1, cfgWord(1'b0, 1'b0, 1'b0, 2'd3));
    writeReg(2'd2, lo);
    writeReg(2'd3, hi);
    writeReg(2'd1, c);
  endtask

  task automatic t_reset();
    expectPin(1'b1, "R1 idle after reset");
    writeReg(2'd1, cfgWord(1'b0, 1'b0, 1'b0, 2'd0));
    sample(16'h7FF0); expectPin(1'b1, "R1 max result vs default high");
    writeReg(2'd1, cfgWord(1'b1, 1'b0, 1'b0, 2'd0));
    sample(16'h8000); expectPin(1'b1, "R1 min result vs default low");
  endtask

  task automatic t_disable();
    setup(16'hFF00, 16'h0100, cfgWord(1'b0, 1'b0, 1'b0, 2'd3));
    for (int i = 0; i < 3; i++) sample(16'h7000);
    expectPin(1'b1, "R2 queue off stays quiet");
    writeReg(2'd1, cfgWord(1'b0, 1'b0, 1'b0, 2'd0));
    sample(16'h7000); expectPin(1'b0, "R2 enabled alert");
    writeReg(2'd1, cfgWord(1'b0, 1'b0, 1'b0, 2'd3));
    expectPin(1'b1, "R2 disable write clears");
  endtask

  task automatic t_traditional();
    setup(16'hFF00, 16'h0100, cfgWord(1'b0, 1'b0, 1'b0, 2'd0));
    sample(16'h0100); expectPin(1'b1, "R3 equal to high no alert");
    sample(16'h0110); expectPin(1'b0, "R3 above high alerts");
    sample(16'h0000); expectPin(1'b0, "R4 hysteresis holds");
    sample(16'hFF00); expectPin(1'b0, "R4 equal to low holds");
    sample(16'hFE00); expectPin(1'b1, "R4 below low releases");
    sample(16'h0050); expectPin(1'b1, "R4 stays released");
  endtask

  task automatic t_window();
    setup(16'hFF00, 16'h0100, cfgWord(1'b1, 1'b0, 1'b0, 2'd0));
    sample(16'hFE00); expectPin(1'b0, "R5 below low alerts");
    sample(16'h0000); expectPin(1'b1, "R5 in band releases");
    sample(16'h0200); expectPin(1'b0, "R5 above high alerts");
    sample(16'h0080); expectPin(1'b1, "R5 in band releases again");
  endtask

  task automatic t_queue();
    setup(16'hFF00, 16'h0100, cfgWord(1'b0, 1'b0, 1'b0, 2'd1));
    sample(16'h0200); expectPin(1'b1, "R6 code1 one hit not enough");
    sample(16'h0200); expectPin(1'b0, "R6 code1 two hits fire");
    sample(16'hFE00);
    writeReg(2'd1, cfgWord(1'b0, 1'b0, 1'b0, 2'd2));
    for (int i = 0; i < 3; i++) sample(16'h0200);
    expectPin(1'b1, "R6 code2 three hits not enough");
    sample(16'h0000);
    for (int i = 0; i < 3; i++) sample(16'h0200);
    expectPin(1'b1, "R6 in-range result resets run");
    sample(16'h0200); expectPin(1'b0, "R6 code2 four hits fire");
  endtask

  task automatic t_latch();
    setup(16'hFF00, 16'h0100, cfgWord(1'b0, 1'b0, 1'b1, 2'd0));
    sample(16'h0200); expectPin(1'b0, "R7 latched alert set");
    sample(16'hFE00); expectPin(1'b0, "R7 held past low");
    sample(16'h0000); expectPin(1'b0, "R7 held in band");
    readConv();       expectPin(1'b1, "R7 read clears");
    readConv();       expectPin(1'b1, "R7 second read stays clear");
  endtask

  task automatic t_read_ignored();
    setup(16'hFF00, 16'h0100, cfgWord(1'b0, 1'b0, 1'b0, 2'd0));
    sample(16'h0200); expectPin(1'b0, "R8 alert set");
    readConv();       expectPin(1'b0, "R8 read ignored unlatched");
  endtask

  task automatic t_polarity();
    setup(16'hFF00, 16'h0100, cfgWord(1'b0, 1'b1, 1'b0, 2'd0));
    expectPin(1'b0, "R9 active-high idle");
    sample(16'h0200); expectPin(1'b1, "R9 active-high asserted");
  endtask

  task automatic t_signed_width();
    setup(16'hFF00, 16'h0100, cfgWord(1'b0, 1'b0, 1'b0, 2'd0));
    sample(16'h010F); expectPin(1'b1, "R10 pad bits ignored");
    sample(16'hFF00); expectPin(1'b1, "R10 negative not above high");
    setup(16'h0000, 16'h0100, cfgWord(1'b1, 1'b0, 1'b0, 2'd0));
    sample(16'hFFF0); expectPin(1'b0, "R10 minus one below zero");
    sample(16'h000F); expectPin(1'b1, "R10 zero with pad in band");
  endtask

  task automatic t_queue_change();
    setup(16'hFF00, 16'h0100, cfgWord(1'b0, 1'b0, 1'b0, 2'd2));
    for (int i = 0; i < 3; i++) sample(16'h0200);
    writeReg(2'd1, cfgWord(1'b0, 1'b0, 1'b0, 2'd1));
    sample(16'h0200); expectPin(1'b1, "R11 run reset by queue change");
    sample(16'h0200); expectPin(1'b0, "R11 fires after new run");
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finishRun();
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    sampleValid = 1'b0; sampleData = '0; convRead = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_disable();
    t_traditional();
    t_window();
    t_queue();
    t_latch();
    t_read_ignored();
    t_polarity();
    t_signed_width();
    t_queue_change();
    finishRun();
  end

endmodule